// File: doc/BRIEF.md
# I2C Register-Read Target

This block is an I2C target that gives a bus master byte access to an internal array of 256 bytes. A fast system clock oversamples SCL and SDA through a two-flop synchroniser. Edge detection on the synchronised lines finds SCL rising and falling edges, START conditions (SDA falling while SCL is high) and STOP conditions (SDA rising while SCL is high). SDA is open-drain. The block only ever pulls it low, through `sda_oe`.

A write transaction carries a one-byte word address that loads the internal pointer. Any bytes after it are stored at the pointer, and the pointer steps after each byte. A read transaction starts at the pointer and returns one byte for each master ACK. This gives three read styles:
- Current-address reads continue from where the previous access stopped.
- Random reads use a write of the word address followed by a repeated START.
- Sequential reads go on for as long as the master keeps acknowledging.

The pointer persists between transactions and wraps from 0xFF to 0x00. A single select pin chooses between two bus addresses.

Top module: `i2c_regread_target`

## Requirements
- R1: The target answers to the 8-bit address byte 0x50 (write) / 0x51 (read) when `addr_sel` is 0, and to 0x52 / 0x53 when `addr_sel` is 1. Bit 0 of the byte is R/W, with 1 meaning read. A match is acknowledged by pulling SDA low (`sda_oe`=1) during the ninth clock.
- R2: An address byte that does not match is not acknowledged. The target then drives nothing until the next START, and its pointer keeps its value.
- R3: In a write transaction, the byte after the address byte loads the pointer. Each further byte is stored at the pointer and acknowledged, and the pointer then steps by one, wrapping from 0xFF to 0x00.
- R4: After an acknowledged read address byte, the target shifts out the byte at the pointer, MSB first. Once a byte has been sent, the pointer holds its address plus one, so a later current-address read continues from there.
- R5: A random read is a write of the address byte and word address, followed by a repeated START and the read address byte. It returns the byte at the given word address.
- R6: When the master ACKs (SDA low) in the ninth clock of a read byte, the next sequential byte follows. The address wraps from 0xFF to 0x00.
- R7: When the master NACKs (SDA high) in the ninth clock, the read ends and SDA is released. The following current-address read returns the next byte.
- R8: A STOP raised in the ninth clock of a read byte ends the read, and the pointer does not advance past the byte already sent.
- R9: A START or STOP in any state abandons the transfer in progress. A partly received data byte is not stored, and after a START the target expects an address byte.
- R10: `sda_oe` is 0 in reset and changes only while SCL is low. `sda_oe`=1 means SDA is pulled low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oversampling system clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| addr_sel | input | 1 | Chooses between the two bus addresses |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad (wired level) |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |

## Verification
The read path is driven in four ways:
- A random read over a freshly written region checks that the word address lands in the pointer.
- Back-to-back current-address reads check that the pointer persists between transactions.
- A burst across the top of the array tells wrap-around apart from saturation.
- A pair of reads, one ended by NACK and one by a STOP in the ninth clock, checks that both endings leave the pointer one past the last byte sent.

Foreign and swapped addresses, which depend on the select pin, check that only the selected address pair is acknowledged. A START in the middle of a data byte checks that the partial byte is dropped and not stored. A behavioural model (a byte array and a pointer) predicts every returned byte, and the bus is also watched every clock for drive changes while SCL is high.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int BYTE_W = 8;
  localparam int BITCNT_W = $clog2(BYTE_W);

  // Transfer engine states
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,  // waiting for START
    ST_ADDR  = 3'd1,  // receiving address byte
    ST_WADDR = 3'd2,  // receiving word address
    ST_WDATA = 3'd3,  // receiving data to store
    ST_ACK   = 3'd4,  // target pulls SDA low for one clock
    ST_RDATA = 3'd5,  // shifting a byte out
    ST_RACK  = 3'd6   // master acknowledge slot
  } tgt_state_e;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_det,
  output logic stop_det
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [STAGES-1:0] scl_pipe, scl_pipe_n;
  logic [STAGES-1:0] sda_pipe, sda_pipe_n;
  logic scl_q, sda_q;
  logic scl_s;

  always_comb begin
    scl_pipe_n = {scl_pipe[STAGES-2:0], scl_i};
    sda_pipe_n = {sda_pipe[STAGES-2:0], sda_i};
  end

  // Idle bus is high on both lines, so reset to 1 to avoid false edges
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
    end else begin
      scl_pipe <= scl_pipe_n;
      sda_pipe <= sda_pipe_n;
      scl_q    <= scl_pipe[STAGES-1];
      sda_q    <= sda_pipe[STAGES-1];
    end
  end

  assign scl_s     = scl_pipe[STAGES-1];
  assign sda_s     = sda_pipe[STAGES-1];
  assign scl_rise  = scl_s & ~scl_q;
  assign scl_fall  = ~scl_s & scl_q;
  assign start_det = scl_s & scl_q & sda_q & ~sda_s;
  assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/i2c_reg_array.sv
module i2c_reg_array #(
  parameter int AW = 8
) (
  input  logic                          clk,
  input  logic                          wr_en,
  input  logic [AW-1:0]                 wr_addr,
  input  logic [i2c_tgt_pkg::BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]                 rd_addr,
  output logic [i2c_tgt_pkg::BYTE_W-1:0] rd_data
);
  timeunit 1ns;
  timeprecision 1ps;

  localparam int DEPTH = 1 << AW;

  logic [i2c_tgt_pkg::BYTE_W-1:0] mem [DEPTH];

  // Storage array: contents are not reset
  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
  end

  assign rd_data = mem[rd_addr];
endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int         AW       = 8,
  parameter logic [6:0] DEV_ID   = 7'h28,
  parameter logic [6:0] SEL_MASK = 7'h01
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              addr_sel,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic [AW-1:0]     ptr_o,
  output tgt_state_e        state_o,
  output logic              sda_oe
);
  timeunit 1ns;
  timeprecision 1ps;

  tgt_state_e          st, st_n, ret, ret_n;
  logic [BITCNT_W-1:0] cnt, cnt_n;
  logic                full, full_n;
  logic [BYTE_W-1:0]   sh, sh_n;
  logic [BYTE_W-1:0]   tx, tx_n;
  logic [AW-1:0]       ptr, ptr_n;
  logic                mack, mack_n;
  logic                addr_hit;
  logic [6:0]          own_addr;

  assign own_addr = addr_sel ? (DEV_ID | SEL_MASK) : DEV_ID;
  assign addr_hit = (sh[BYTE_W-1:1] == own_addr);

  always_comb begin
    st_n   = st;
    ret_n  = ret;
    cnt_n  = cnt;
    full_n = full;
    sh_n   = sh;
    tx_n   = tx;
    ptr_n  = ptr;
    mack_n = mack;
    wr_en  = 1'b0;
    if (stop_det) begin
      st_n   = ST_IDLE;
      cnt_n  = '0;
      full_n = 1'b0;
    end else if (start_det) begin
      st_n   = ST_ADDR;
      cnt_n  = '0;
      full_n = 1'b0;
    end else begin
      unique case (st)
        ST_ADDR, ST_WADDR, ST_WDATA: begin
          if (scl_rise) begin
            sh_n  = {sh[BYTE_W-2:0], sda_s};
            cnt_n = cnt + 1'b1;
            if (cnt == BITCNT_W'(BYTE_W - 1)) full_n = 1'b1;
          end else if (scl_fall && full) begin
            full_n = 1'b0;
            cnt_n  = '0;
            if (st == ST_ADDR) begin
              if (addr_hit) begin
                st_n  = ST_ACK;
                ret_n = sh[0] ? ST_RDATA : ST_WADDR;
              end else begin
                st_n = ST_IDLE;
              end
            end else if (st == ST_WADDR) begin
              ptr_n = sh[AW-1:0];
              st_n  = ST_ACK;
              ret_n = ST_WDATA;
            end else begin
              wr_en = 1'b1;
              ptr_n = ptr + 1'b1;
              st_n  = ST_ACK;
              ret_n = ST_WDATA;
            end
          end
        end
        ST_ACK: begin
          if (scl_fall) begin
            st_n  = ret;
            cnt_n = '0;
            if (ret == ST_RDATA) begin
              tx_n  = rd_data;
              ptr_n = ptr + 1'b1;
            end
          end
        end
        ST_RDATA: begin
          if (scl_fall) begin
            if (cnt == BITCNT_W'(BYTE_W - 1)) begin
              st_n  = ST_RACK;
              cnt_n = '0;
            end else begin
              tx_n  = {tx[BYTE_W-2:0], 1'b0};
              cnt_n = cnt + 1'b1;
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack_n = ~sda_s;
          end else if (scl_fall) begin
            if (mack) begin
              st_n  = ST_RDATA;
              tx_n  = rd_data;
              ptr_n = ptr + 1'b1;
            end else begin
              st_n = ST_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= ST_IDLE;
      ret  <= ST_IDLE;
      cnt  <= '0;
      full <= 1'b0;
      sh   <= '0;
      tx   <= '0;
      ptr  <= '0;
      mack <= 1'b0;
    end else begin
      st   <= st_n;
      ret  <= ret_n;
      cnt  <= cnt_n;
      full <= full_n;
      sh   <= sh_n;
      tx   <= tx_n;
      ptr  <= ptr_n;
      mack <= mack_n;
    end
  end

  assign wr_data = sh;
  assign ptr_o   = ptr;
  assign state_o = st;
  assign sda_oe  = (st == ST_ACK) | ((st == ST_RDATA) & ~tx[BYTE_W-1]);
endmodule

// File: rtl/i2c_regread_target.sv
module i2c_regread_target
  import i2c_tgt_pkg::*;
#(
  parameter int         AW          = 8,
  parameter logic [6:0] DEV_ID      = 7'h28,
  parameter logic [6:0] SEL_MASK    = 7'h01,
  parameter int         SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic addr_sel,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe
);
  timeunit 1ns;
  timeprecision 1ps;

  logic [1:0] rst_pipe;
  logic       rst_int_n;

  // Reset asserts asynchronously, releases on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_int_n = rst_pipe[1];

  logic sda_s, scl_rise, scl_fall, start_det, stop_det;
  logic              wr_en;
  logic [BYTE_W-1:0] wr_data, rd_data;
  logic [AW-1:0]     fsm_ptr;
  tgt_state_e        fsm_state;

  i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .scl_i     (scl_i),
    .sda_i     (sda_i),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det)
  );

  i2c_tgt_fsm #(.AW(AW), .DEV_ID(DEV_ID), .SEL_MASK(SEL_MASK)) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .addr_sel  (addr_sel),
    .sda_s     (sda_s),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_det (start_det),
    .stop_det  (stop_det),
    .rd_data   (rd_data),
    .wr_en     (wr_en),
    .wr_data   (wr_data),
    .ptr_o     (fsm_ptr),
    .state_o   (fsm_state),
    .sda_oe    (sda_oe)
  );

  i2c_reg_array #(.AW(AW)) u_mem (
    .clk     (clk),
    .wr_en   (wr_en),
    .wr_addr (fsm_ptr),
    .wr_data (wr_data),
    .rd_addr (fsm_ptr),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/i2c_regread_checker.sv
module i2c_regread_checker
  import i2c_tgt_pkg::*;
#(
  parameter int AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          scl_i,
  input logic          sda_oe,
  input tgt_state_e    st,
  input logic [AW-1:0] ptr,
  input logic          start_det,
  input logic          stop_det
);
  timeunit 1ns;
  timeprecision 1ps;

  // R10
  sda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_i && $past(scl_i)) |-> $stable(sda_oe))
    else $error("sda_oe moved while SCL high");

  // R2
  idle_exit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_IDLE) |=> (st == ST_IDLE || st == ST_ADDR))
    else $error("left idle without a START");

  // R8
  stop_ninth_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RACK && stop_det) |=> (ptr == $past(ptr)))
    else $error("pointer moved on STOP in ninth clock");

  // R6
  read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st == ST_RDATA) |-> (ptr == $past(ptr) + 1'b1))
    else $error("read pointer did not step by one");

  // R9
  start_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> (st == ST_ADDR))
    else $error("START did not restart address reception");
endmodule

bind i2c_regread_target i2c_regread_checker #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .scl_i     (scl_i),
  .sda_oe    (sda_oe),
  .st        (fsm_state),
  .ptr       (fsm_ptr),
  .start_det (start_det),
  .stop_det  (stop_det)
);

// File: tb/test_i2c_regread_target.sv
module test_i2c_regread_target;
  timeunit 1ns;
  timeprecision 1ps;

  localparam int Q = 8;  // system clocks per quarter SCL period

  logic clk = 1'b0;
  always #2 clk = ~clk;  // 250 MHz

  logic rst_n, addr_sel, scl_m, sda_m;
  logic sda_oe;
  logic sda_line;
  assign sda_line = sda_m & ~sda_oe;

  i2c_regread_target i_i2c_regread_target (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr_sel (addr_sel),
    .scl_i    (scl_m),
    .sda_i    (sda_line),
    .sda_oe   (sda_oe)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic [7:0] ref_mem [256];
  int  ref_ptr = 0;
  bit  quiet = 0;
  bit  mon_on = 0;
  bit  done = 0;
  logic scl_prev = 1'b1;
  logic oe_prev = 1'b0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Per-clock bus watch
  always @(negedge clk) begin
    #1;
    if (mon_on) begin
      if (scl_m && scl_prev) check("R10 drive steady while SCL high", {31'd0, sda_oe}, {31'd0, oe_prev});
      if (quiet) check("R2 no drive after foreign address", {31'd0, sda_oe}, 32'd0);
    end
    scl_prev = scl_m;
    oe_prev  = sda_oe;
  end

  task automatic hq();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bit_x(input logic b, output logic r);
    sda_m = b; hq();
    scl_m = 1'b1; hq();
    r = sda_line; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic start_c();
    sda_m = 1'b1; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b0; hq();
    scl_m = 1'b0; hq();
  endtask

  task automatic stop_c();
    sda_m = 1'b0; hq();
    scl_m = 1'b1; hq();
    sda_m = 1'b1; hq();
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_x(b[i], r);
    bit_x(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv8(output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_x(1'b1, r);
      b[i] = r;
    end
  endtask

  task automatic rd_body(input int n, input bit stop9, input string req);
    logic [7:0] b;
    logic r;
    for (int i = 0; i < n; i++) begin
      recv8(b);
      check(req, {24'd0, b}, {24'd0, ref_mem[ref_ptr]});
      ref_ptr = (ref_ptr + 1) % 256;
      if (i == n - 1) begin
        if (!stop9) bit_x(1'b1, r);  // NACK
      end else begin
        bit_x(1'b0, r);              // ACK
      end
    end
    stop_c();
  endtask

  task automatic wr_txn(input logic [7:0] dev, input logic [7:0] wa, input int n,
                        input logic [7:0] seed, input string req);
    logic a;
    logic [7:0] d;
    start_c();
    send_byte(dev, a);  check({req, " address ack"}, {31'd0, a}, 32'd1);
    send_byte(wa, a);   check({req, " word address ack"}, {31'd0, a}, 32'd1);
    ref_ptr = wa;
    for (int i = 0; i < n; i++) begin
      d = seed + 8'(i * 29);
      send_byte(d, a);
      check({req, " data ack"}, {31'd0, a}, 32'd1);
      ref_mem[ref_ptr] = d;
      ref_ptr = (ref_ptr + 1) % 256;
    end
    stop_c();
  endtask

  task automatic cur_rd(input logic [7:0] dev, input int n, input bit stop9, input string req);
    logic a;
    start_c();
    send_byte(dev | 8'h01, a);
    check({req, " read address ack"}, {31'd0, a}, 32'd1);
    rd_body(n, stop9, req);
  endtask

  task automatic rand_rd(input logic [7:0] dev, input logic [7:0] wa, input int n, input string req);
    logic a;
    start_c();
    send_byte(dev, a); check({req, " address ack"}, {31'd0, a}, 32'd1);
    send_byte(wa, a);  check({req, " word address ack"}, {31'd0, a}, 32'd1);
    ref_ptr = wa;
    start_c();
    send_byte(dev | 8'h01, a); check({req, " read address ack"}, {31'd0, a}, 32'd1);
    rd_body(n, 1'b0, req);
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    logic a;
    rst_n = 1'b0; scl_m = 1'b1; sda_m = 1'b1; addr_sel = 1'b0;
    repeat (5) @(negedge clk);
    check("R10 reset releases SDA", {31'd0, sda_oe}, 32'd0);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    check("R10 idle after reset releases SDA", {31'd0, sda_oe}, 32'd0);
    mon_on = 1;

    // R1 R3: fill two regions
    wr_txn(8'h50, 8'h00, 8, 8'hA5, "R1 R3 write low region");
    wr_txn(8'h50, 8'h10, 6, 8'h3C, "R3 write mid region");

    // R5 R4 R6: random read with sequential continuation
    rand_rd(8'h50, 8'h10, 3, "R5 random read");
    // R4 R7: current-address continues after NACK
    cur_rd(8'h50, 2, 1'b0, "R7 current read after NACK");
    // R8: STOP in ninth clock, then next current read
    cur_rd(8'h50, 1, 1'b1, "R8 read ended by STOP");
    cur_rd(8'h50, 1, 1'b0, "R8 pointer after STOP end");

    // R3 R6: wrap across the top of the array
    wr_txn(8'h50, 8'hFE, 4, 8'h71, "R3 write across wrap");
    rand_rd(8'h50, 8'hFE, 4, "R6 sequential read across wrap");

    // R2: foreign address ignored, pointer unchanged
    quiet = 1;
    start_c();
    send_byte(8'h52, a); check("R2 foreign address not acked", {31'd0, a}, 32'd0);
    send_byte(8'h10, a); check("R2 following byte not acked", {31'd0, a}, 32'd0);
    stop_c();
    quiet = 0;
    cur_rd(8'h50, 1, 1'b0, "R2 pointer kept after foreign address");

    // R1: select pin moves the address
    addr_sel = 1'b1;
    repeat (4) @(negedge clk);
    wr_txn(8'h52, 8'h20, 2, 8'h18, "R1 write at selected address");
    quiet = 1;
    start_c();
    send_byte(8'h50, a); check("R1 unselected address not acked", {31'd0, a}, 32'd0);
    stop_c();
    quiet = 0;
    rand_rd(8'h52, 8'h20, 2, "R1 read at selected address");
    addr_sel = 1'b0;
    repeat (4) @(negedge clk);

    // R9: START in the middle of a data byte
    start_c();
    send_byte(8'h50, a); check("R9 address ack", {31'd0, a}, 32'd1);
    send_byte(8'h05, a); check("R9 word address ack", {31'd0, a}, 32'd1);
    ref_ptr = 5;
    for (int i = 0; i < 4; i++) begin
      logic r;
      bit_x(1'b0, r);
    end
    start_c();
    send_byte(8'h51, a); check("R9 read address after abort ack", {31'd0, a}, 32'd1);
    rd_body(1, 1'b0, "R9 partial byte not stored");

    repeat (20) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule